// File: doc/BRIEF.md
# Grayscale Pulse-Width Pixel Driver

This block turns 4-bit pixel gray levels into a drive pulse whose length comes from a programmable table of 16 widths. Each stored frame byte carries two pixels. A parity input picks which half of the byte applies to the current pixel. The block looks up the width for that level and holds its drive output high for that many ticks at the start of a fixed-length pixel slot.

Before any pixel data is sent, the table is loaded through a small register port. That port has a write strobe, an address, write data, and a combinational read-back of the addressed entry. Entry 0 always holds zero, so level 0 always means the pixel is off. Every other entry is limited to the range 0..180. A write above that range is saturated and sets a sticky error flag.

Pixels enter through a valid/ready handshake. Ready is only high at slot boundaries, so a stream can run back to back with no idle tick between slots.

Top module: `gs_pixel_driver`

## Requirements
- R1: After reset, entry L (1..15) reads 12*L, entry 0 reads 0, `cfg_err_o` is 0, `pix_ready_o` is 1 and `drive_o` is 0.
- R2: Entry 0 always reads 0. Writes to address 0 change nothing, including `cfg_err_o`, for every write value.
- R3: A write of value V <= 180 to address A in 1..15 stores V. `cfg_rdata_o` shows the entry addressed by `cfg_addr_i` in the same cycle.
- R4: A write of V > 180 to address 1..15 stores 180 and sets `cfg_err_o`. The flag stays set until reset.
- R5: When `pix_odd_i`=0 the gray level is `pix_byte_i[7:4]`. When `pix_odd_i`=1 it is `pix_byte_i[3:0]`.
- R6: A slot lasts 181 ticks, counted from the first tick after the accepting edge. `drive_o` is high on ticks 0..N-1 and low on ticks N..180, where N is the table entry of the pixel's level.
- R7: `pix_ready_o` is low on ticks 0..179 of a slot and high on tick 180. A `pix_valid_i` raised while ready is low has no effect on the slot.
- R8: A pixel presented on tick 180 is accepted at the next edge, and its slot starts with no gap.
- R9: The width is captured when the pixel is accepted. A table write during a slot does not change that slot, but it applies to later pixels.
- R10: When a slot ends with no new pixel, the block goes idle: `drive_o` is 0 and `pix_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_addr_i | input | 4 | Table address for both write and read-back |
| cfg_wdata_i | input | 8 | Width value to write |
| cfg_rdata_o | output | 8 | Stored width at `cfg_addr_i` |
| cfg_err_o | output | 1 | Sticky flag for a saturated write |
| pix_valid_i | input | 1 | Pixel request |
| pix_ready_o | output | 1 | Ready for a pixel (slot boundary or idle) |
| pix_byte_i | input | 8 | Stored byte holding two gray levels |
| pix_odd_i | input | 1 | Pixel parity: 0 selects the upper nibble, 1 the lower |
| drive_o | output | 1 | Pixel drive pulse |

## Verification
Two cases are hard to reach from the ports. The first is a table write that lands in the middle of a slot that is already running. The second is a pixel request raised while the block is busy. Neither changes the current pulse, so only the timing of ticks can expose a fault. The stimulus runs back-to-back streams and places both events at fixed tick offsets inside a slot: a write to the level in use at tick 5, and a rogue request over ticks 50..59. It then checks `drive_o` on every tick of that slot and of the following one.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_RUN  = 1'b1
  } slot_state_e;
endpackage

// File: rtl/gs_table.sv
module gs_table #(
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned PW_W      = 8,
  parameter int unsigned PW_MAX    = 180,
  parameter int unsigned RAMP_STEP = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LVL_W-1:0] addr_i,
  input  logic [PW_W-1:0]  wdata_i,
  output logic [PW_W-1:0]  rdata_o,
  input  logic [LVL_W-1:0] laddr_i,
  output logic [PW_W-1:0]  ldata_o,
  output logic             err_o
);
  localparam int unsigned NUM = 1 << LVL_W;
  localparam logic [PW_W-1:0] CAP = PW_W'(PW_MAX);

  logic [NUM*PW_W-1:0] tbl_flat;
  logic [PW_W-1:0]     wval;
  logic                over;
  logic                err_q;

  assign over = wdata_i > CAP;
  assign wval = over ? CAP : wdata_i;

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign tbl_flat[0 +: PW_W] = '0;
    end else begin : g_reg
      localparam int unsigned RAMP = RAMP_STEP * i;
      localparam int unsigned RST_V = (RAMP > PW_MAX) ? PW_MAX : RAMP;
      logic [PW_W-1:0] ent_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 ent_q <= PW_W'(RST_V);
        else if (we_i && addr_i == LVL_W'(i))        ent_q <= wval;
      end
      assign tbl_flat[i*PW_W +: PW_W] = ent_q;

      a_r3_entry_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ent_q <= CAP);
    end
  end

  // entry 0 never flags: writes there are dropped entirely
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           err_q <= 1'b0;
    else if (we_i && addr_i != '0 && over) err_q <= 1'b1;
  end

  assign rdata_o = tbl_flat[addr_i*PW_W +: PW_W];
  assign ldata_o = tbl_flat[laddr_i*PW_W +: PW_W];
  assign err_o   = err_q;

  a_r4_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r2_level0_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (laddr_i == '0) |-> (ldata_o == '0));
endmodule

// File: rtl/gs_nibble_sel.sv
module gs_nibble_sel #(
  parameter int unsigned LVL_W = 4
) (
  input  logic [2*LVL_W-1:0] byte_i,
  input  logic               odd_i,
  output logic [LVL_W-1:0]   lvl_o
);
  // even pixel in the upper half, odd pixel in the lower half
  assign lvl_o = odd_i ? byte_i[LVL_W-1:0] : byte_i[2*LVL_W-1:LVL_W];
endmodule

// File: rtl/gs_slot_pwm.sv
module gs_slot_pwm
  import gs_pkg::*;
#(
  parameter int unsigned PW_W   = 8,
  parameter int unsigned PW_MAX = 180
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [PW_W-1:0] width_i,
  output logic            ready_o,
  output logic            drive_o
);
  localparam int unsigned CNT_W = $clog2(PW_MAX + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PW_MAX);

  slot_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW_W-1:0]  wid_q;
  logic             last;

  assign last    = cnt_q == LAST;
  assign ready_o = (state_q == SLOT_IDLE) || last;
  assign drive_o = (state_q == SLOT_RUN) && (PW_W'(cnt_q) < wid_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_IDLE;
      cnt_q   <= '0;
      wid_q   <= '0;
    end else if (start_i) begin
      state_q <= SLOT_RUN;
      cnt_q   <= '0;
      wid_q   <= width_i;
    end else if (state_q == SLOT_RUN) begin
      if (last) begin
        state_q <= SLOT_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  a_r7_ready_mid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_RUN && !last) |-> !ready_o);
  a_r9_width_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_RUN && cnt_q != '0) |-> $stable(wid_q));
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_RUN && cnt_q != '0 && !$past(drive_o)) |-> !drive_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_IDLE) |-> (!drive_o && ready_o));
endmodule

// File: rtl/gs_pixel_driver.sv
module gs_pixel_driver #(
  parameter int unsigned LVL_W     = 4,
  parameter int unsigned PW_W      = 8,
  parameter int unsigned PW_MAX    = 180,
  parameter int unsigned RAMP_STEP = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [LVL_W-1:0]   cfg_addr_i,
  input  logic [PW_W-1:0]    cfg_wdata_i,
  output logic [PW_W-1:0]    cfg_rdata_o,
  output logic               cfg_err_o,
  input  logic               pix_valid_i,
  output logic               pix_ready_o,
  input  logic [2*LVL_W-1:0] pix_byte_i,
  input  logic               pix_odd_i,
  output logic               drive_o
);
  logic [LVL_W-1:0] lvl;
  logic [PW_W-1:0]  lut_w;
  logic             ready;
  logic             start;

  assign start       = pix_valid_i && ready;
  assign pix_ready_o = ready;

  gs_nibble_sel #(.LVL_W(LVL_W)) u_sel (
    .byte_i (pix_byte_i),
    .odd_i  (pix_odd_i),
    .lvl_o  (lvl)
  );

  gs_table #(
    .LVL_W(LVL_W), .PW_W(PW_W), .PW_MAX(PW_MAX), .RAMP_STEP(RAMP_STEP)
  ) u_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .laddr_i (lvl),
    .ldata_o (lut_w),
    .err_o   (cfg_err_o)
  );

  gs_slot_pwm #(.PW_W(PW_W), .PW_MAX(PW_MAX)) u_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .width_i (lut_w),
    .ready_o (ready),
    .drive_o (drive_o)
  );

  a_r6_first_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (drive_o == ($past(lut_w) != '0)));
  a_r8_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !pix_ready_o);
endmodule

// File: tb/gs_pixel_driver_tb_top.sv
`timescale 1ns/1ps
module gs_pixel_driver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       cfg_err;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [7:0] pix_byte = '0;
  logic       pix_odd = 1'b0;
  logic       drive;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int tbl_m [16];
  logic [7:0] s_byte [64];
  logic       s_odd  [64];

  always #2 clk = ~clk;

  gs_pixel_driver dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .cfg_err_o(cfg_err),
    .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .pix_byte_i(pix_byte), .pix_odd_i(pix_odd), .drive_o(drive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 180) ? 180 : v;
  endfunction

  function automatic int nib(input logic [7:0] b, input logic odd);
    return odd ? int'(b[3:0]) : int'(b[7:4]);
  endfunction

  task automatic cfg_write(input int a, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 16; i++) tbl_m[i] = sat(12 * i);
  endtask

  task automatic check_ramp();
    for (int i = 0; i < 16; i++) begin
      cfg_addr = 4'(i); #0.5;
      chk(cfg_rdata == 8'(12 * i), "R1 reset ramp", cfg_rdata, 12 * i);
    end
    chk(cfg_err == 1'b0, "R1 err clear", cfg_err, 0);
    chk(pix_ready == 1'b1, "R1 ready idle", pix_ready, 1);
    chk(drive == 1'b0, "R1 drive low", drive, 0);
  endtask

  // poke: table write to entry pa during ticks 5..6 of the first slot
  task automatic run_stream(input int n, input bit poke, input int pa, input int pv);
    @(negedge clk);
    chk(pix_ready == 1'b1, "R10 idle before stream", pix_ready, 1);
    pix_valid = 1'b1; pix_byte = s_byte[0]; pix_odd = s_odd[0];
    for (int p = 0; p < n; p++) begin
      int expw;
      expw = tbl_m[nib(s_byte[p], s_odd[p])];
      @(posedge clk); #0.5;
      pix_valid = 1'b0;
      for (int k = 0; k < 181; k++) begin
        @(negedge clk);
        chk(drive == (k < expw), "R6 R5 drive tick", drive, int'(k < expw));
        chk(pix_ready == (k == 180), "R7 ready boundary", pix_ready, int'(k == 180));
        if (poke && p == 0 && k == 5) begin
          cfg_we = 1'b1; cfg_addr = 4'(pa); cfg_wdata = 8'(pv);
        end
        if (poke && p == 0 && k == 6) begin
          cfg_we = 1'b0; tbl_m[pa] = sat(pv);
        end
        if (k == 50) begin
          pix_valid = 1'b1; pix_byte = 8'hF0 ^ s_byte[p]; pix_odd = ~s_odd[p];
        end
        if (k == 60) pix_valid = 1'b0;
        if (k == 180 && p < n - 1) begin
          pix_valid = 1'b1; pix_byte = s_byte[p+1]; pix_odd = s_odd[p+1];
        end
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(drive == 1'b0 && pix_ready == 1'b1, "R10 idle after stream",
          {drive, pix_ready}, 1);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_ramp();

    // R2: every value to entry 0
    for (int v = 0; v < 256; v++) begin
      cfg_write(0, v);
      cfg_addr = 4'd0; #0.5;
      chk(cfg_rdata == 8'd0, "R2 entry0 zero", cfg_rdata, 0);
      chk(cfg_err == 1'b0, "R2 entry0 no err", cfg_err, 0);
    end

    // R3/R4: every value to every writable entry
    begin
      bit seen = 1'b0;
      for (int e = 1; e < 16; e++) begin
        for (int v = 0; v < 256; v++) begin
          cfg_write(e, v);
          if (v > 180) seen = 1'b1;
          cfg_addr = 4'(e); #0.5;
          chk(cfg_rdata == 8'(sat(v)), v > 180 ? "R4 saturate" : "R3 store",
              cfg_rdata, sat(v));
          chk(cfg_err == seen, "R4 sticky err", cfg_err, seen);
        end
      end
    end

    do_reset();
    check_ramp();

    // distinct widths including 0 and 180
    for (int i = 1; i < 16; i++) begin
      int w;
      w = (i == 1) ? 0 : (i == 15) ? 180 : (i * 37) % 181;
      cfg_write(i, w);
      tbl_m[i] = w;
    end
    for (int i = 0; i < 16; i++) begin
      cfg_addr = 4'(i); #0.5;
      chk(cfg_rdata == 8'(tbl_m[i]), "R3 program", cfg_rdata, tbl_m[i]);
    end

    // R5 R6 R7 R8: all levels, both parities, back to back
    for (int p = 0; p < 32; p++) begin
      int l;
      l = p / 2;
      s_odd[p]  = p[0];
      s_byte[p] = s_odd[p] ? {4'(15 - l), 4'(l)} : {4'(l), 4'(15 - l)};
    end
    run_stream(32, 1'b0, 0, 0);
    chk(cfg_err == 1'b0, "R4 no err yet", cfg_err, 0);

    // R9: table write to the active level in the middle of the slot
    for (int p = 0; p < 3; p++) begin
      s_byte[p] = 8'h5A; s_odd[p] = 1'b0;
    end
    run_stream(3, 1'b1, 5, 250);
    chk(cfg_err == 1'b1, "R4 err after midslot write", cfg_err, 1);
    cfg_addr = 4'd5; #0.5;
    chk(cfg_rdata == 8'd180, "R9 R4 new width stored", cfg_rdata, 180);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule